// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter

This block turns bytes taken from a transmit queue into asynchronous serial frames on a single output line. Each frame starts with a low start bit and carries eight data bits, least significant first. An optional parity bit follows the data, and the frame ends with one or two high stop bits. A 4-bit format word selects the frame shape. The bit period is set by a clock divisor, so the bit rate is the input clock divided by that value.

The queue itself sits outside the block and is a show-ahead FIFO. Its head byte is valid whenever it reports not-empty, and the block removes the byte with a one-cycle pop strobe. Once a frame ends and the queue is empty, the block raises a done level that a register block can use as its transmit-complete flag. A synchronous soft reset abandons the frame on the line. That frame is never finished and raises no completion afterwards.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is high and `busy` is low; `tx_done` is low after reset.
- R2: A frame is a low start bit, then the eight bits of the popped byte with bit 0 first, then the stop bits, which are high.
- R3: `fmt[3:1]` selects parity. 3'b000 sends an even parity bit and 3'b001 sends an odd parity bit, in both cases over the eight data bits and placed right after them. 3'b111 and every other code send no parity bit.
- R4: `fmt[0]` = 1 sends two stop bits; `fmt[0]` = 0 sends one.
- R5: Every bit is held for `divisor` clock cycles, with a divisor of 0 treated as 1. `busy` stays high for exactly (bits in frame) x divisor cycles per frame.
- R6: `fifo_pop` is a one-cycle strobe. It is raised only while `fifo_empty` is low, and only when the engine is idle or ending its last stop bit. The start bit of the next frame appears in the cycle after the pop, so queued bytes go out with no idle gap.
- R7: `tx_done` rises when the last stop bit ends with the queue empty. It falls at the next pop and is never high together with `busy`.
- R8: When `soft_rst` is high, the next cycle shows `busy` low, `txd` high and `tx_done` low, and no pop occurs in that cycle. The aborted frame never resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous abort of the engine |
| fmt | input | 4 | [3:1] parity code, [0] two stop bits |
| divisor | input | DIV_W | Clock cycles per bit |
| fifo_empty | input | 1 | Queue has no byte |
| fifo_data | input | 8 | Head byte of the queue |
| fifo_pop | output | 1 | Remove head byte |
| txd | output | 1 | Serial line |
| busy | output | 1 | Frame on the line |
| tx_done | output | 1 | Queue drained after the last frame |

## Verification
A wrong bit index or shift state shows up as a corrupted data or parity bit in the decoded frame, within the same frame. A wrong bit counter changes the length of the `busy` window, which is measured to the cycle on a single frame for each format. A missing phase, or an extra one, shows up the same way. Faults in the completion or abort logic show up as `tx_done` being wrong at the cycle `busy` falls, or as line activity after `soft_rst`.

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic [3:0]       fmt,
  input  logic [DIV_W-1:0] divisor,
  input  logic             fifo_empty,
  input  logic [7:0]       fifo_data,
  output logic             fifo_pop,
  output logic             txd,
  output logic             busy,
  output logic             tx_done
);
  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t             st;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_m1;
  logic [7:0]      sh;
  logic [2:0]      idx;
  logic            par_on, par_bit, two_stop, stop2nd;
  logic            bit_end, last_bit;

  assign div_m1   = (divisor == '0) ? '0 : divisor - 1'b1;
  assign bit_end  = (cnt == '0);
  assign last_bit = (st == S_STOP) && bit_end && (!two_stop || stop2nd);
  assign fifo_pop = !soft_rst && !fifo_empty && ((st == S_IDLE) || last_bit);
  assign busy     = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; txd <= 1'b1; tx_done <= 1'b0; cnt <= '0;
      sh <= '0; idx <= '0; par_on <= 1'b0; par_bit <= 1'b0;
      two_stop <= 1'b0; stop2nd <= 1'b0;
    end else if (soft_rst) begin
      st <= S_IDLE; txd <= 1'b1; tx_done <= 1'b0; cnt <= '0;
    end else if (fifo_pop) begin
      st       <= S_START;
      txd      <= 1'b0;
      cnt      <= div_m1;
      sh       <= fifo_data;
      idx      <= '0;
      par_on   <= (fmt[3:2] == 2'b00);
      par_bit  <= (^fifo_data) ^ fmt[1];
      two_stop <= fmt[0];
      stop2nd  <= 1'b0;
      tx_done  <= 1'b0;
    end else if (st != S_IDLE) begin
      if (!bit_end) begin
        cnt <= cnt - 1'b1;
      end else begin
        cnt <= div_m1;
        case (st)
          S_START: begin st <= S_DATA; txd <= sh[0]; idx <= '0; end
          S_DATA: begin
            if (idx == 3'd7) begin
              st  <= par_on ? S_PAR : S_STOP;
              txd <= par_on ? par_bit : 1'b1;
            end else begin
              idx <= idx + 1'b1;
              sh  <= sh >> 1;
              txd <= sh[1];
            end
          end
          S_PAR: begin st <= S_STOP; txd <= 1'b1; stop2nd <= 1'b0; end
          S_STOP: begin
            if (last_bit) begin
              st <= S_IDLE; txd <= 1'b1; tx_done <= 1'b1;
            end else begin
              stop2nd <= 1'b1;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module uart_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic soft_rst,
  input logic fifo_empty,
  input logic fifo_pop,
  input logic txd,
  input logic busy,
  input logic tx_done
);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  assert_pop_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);
  assert_start_after_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> (busy && !txd));
  assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && tx_done));
  assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!busy && txd && !tx_done));
  assert_abort_nopop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> !fifo_pop);
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .fifo_empty(fifo_empty),
  .fifo_pop(fifo_pop), .txd(txd), .busy(busy), .tx_done(tx_done)
);

// File: tb/sim_uart_frame_tx.sv
module sim_uart_frame_tx;
  logic clk = 0, rst_n = 0, soft_rst = 0;
  logic [3:0] fmt = 4'b1110;
  logic [15:0] divisor = 16'd4;
  logic fifo_pop, txd, busy, tx_done;
  logic [7:0] mem [0:15];
  logic [3:0] rd, wr;
  logic fifo_empty;
  logic [7:0] fifo_data;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  assign fifo_empty = (rd == wr);
  assign fifo_data  = mem[rd];

  always @(posedge clk or negedge rst_n)
    if (!rst_n) rd <= '0;
    else if (fifo_pop) rd <= rd + 1'b1;

  uart_frame_tx u0 (.clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .fmt(fmt),
    .divisor(divisor), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
    .fifo_pop(fifo_pop), .txd(txd), .busy(busy), .tx_done(tx_done));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    mem[wr] = b;
    wr = wr + 1'b1;
  endtask

  task automatic rx_frame(input int div, input int npar, input int nstop,
                          output logic [7:0] d, output logic p, output bit stop_ok);
    int t = 0;
    @(negedge clk);
    while (txd && t < 5000) begin @(negedge clk); t++; end
    repeat (div / 2) @(negedge clk);
    chk(txd == 0, "R2 start bit low", txd, 0);
    for (int i = 0; i < 8; i++) begin
      repeat (div) @(negedge clk);
      d[i] = txd;
    end
    p = 0;
    if (npar != 0) begin repeat (div) @(negedge clk); p = txd; end
    stop_ok = 1;
    for (int i = 0; i < nstop; i++) begin
      repeat (div) @(negedge clk);
      if (txd !== 1'b1) stop_ok = 0;
    end
  endtask

  task automatic busy_len(input logic [7:0] b, output int n);
    int t = 0;
    push(b);
    while (!busy && t < 100) begin @(negedge clk); t++; end
    n = 0;
    while (busy && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset;
    chk(txd == 1, "R1 reset txd", txd, 1);
    chk(busy == 0, "R1 reset busy", busy, 0);
    chk(tx_done == 0, "R1 reset tx_done", tx_done, 0);
    chk(fifo_pop == 0, "R6 no pop when empty", fifo_pop, 0);
  endtask

  task automatic t_basic;
    logic [7:0] d; logic p; bit s;
    fmt = 4'b1110; divisor = 4;
    fork
      push(8'hA5);
      rx_frame(4, 0, 1, d, p, s);
    join
    chk(d == 8'hA5, "R2 data LSB first", d, 8'hA5);
    chk(s, "R2 stop high", s, 1);
    @(negedge clk);
    while (busy) @(negedge clk);
    chk(tx_done == 1, "R7 done after drain", tx_done, 1);
    chk(txd == 1, "R1 idle high after frame", txd, 1);
    push(8'h01);
    @(negedge clk);
    chk(tx_done == 0, "R7 done cleared by pop", tx_done, 0);
    while (busy) @(negedge clk);
  endtask

  task automatic t_parity;
    logic [7:0] d; logic p; bit s;
    divisor = 6;
    fmt = 4'b0010;
    fork push(8'h03); rx_frame(6, 1, 1, d, p, s); join
    chk(d == 8'h03 && p == 1, "R3 odd parity bit", p, 1);
    @(negedge clk); while (busy) @(negedge clk);
    fmt = 4'b0000;
    fork push(8'h07); rx_frame(6, 1, 1, d, p, s); join
    chk(d == 8'h07 && p == 1, "R3 even parity bit", p, 1);
    @(negedge clk); while (busy) @(negedge clk);
    fmt = 4'b0000;
    fork push(8'h81); rx_frame(6, 1, 1, d, p, s); join
    chk(p == 0, "R3 even parity zero", p, 0);
    @(negedge clk); while (busy) @(negedge clk);
  endtask

  task automatic t_lengths;
    int n;
    divisor = 5; fmt = 4'b1110; busy_len(8'h55, n);
    chk(n == 50, "R5 8N1 length", n, 50);
    fmt = 4'b1111; busy_len(8'h55, n);
    chk(n == 55, "R4 two stop no parity", n, 55);
    fmt = 4'b0011; busy_len(8'h55, n);
    chk(n == 60, "R4 parity two stop", n, 60);
    fmt = 4'b0100; busy_len(8'h55, n);
    chk(n == 50, "R3 other code no parity", n, 50);
    fmt = 4'b1010; busy_len(8'h55, n);
    chk(n == 50, "R3 code 101 no parity", n, 50);
    divisor = 0; fmt = 4'b1110; busy_len(8'h55, n);
    chk(n == 10, "R5 divisor zero as one", n, 10);
    divisor = 1; fmt = 4'b0000; busy_len(8'h55, n);
    chk(n == 11, "R5 divisor one with parity", n, 11);
  endtask

  task automatic t_b2b;
    logic [7:0] d; logic p; bit s;
    int n = 0;
    divisor = 4; fmt = 4'b1110;
    @(negedge clk);
    mem[wr] = 8'h11; mem[wr + 4'd1] = 8'h22; mem[wr + 4'd2] = 8'h33;
    wr = wr + 4'd3;
    rx_frame(4, 0, 1, d, p, s);
    chk(d == 8'h11, "R6 first queued", d, 8'h11);
    chk(tx_done == 0, "R7 no done while queued", tx_done, 0);
    rx_frame(4, 0, 1, d, p, s);
    chk(d == 8'h22, "R6 second queued", d, 8'h22);
    rx_frame(4, 0, 1, d, p, s);
    chk(d == 8'h33, "R6 third queued", d, 8'h33);
    while (busy) @(negedge clk);
    chk(tx_done == 1, "R7 done after last", tx_done, 1);
    @(negedge clk);
    mem[wr] = 8'hF0; mem[wr + 4'd1] = 8'h0F; wr = wr + 4'd2;
    @(negedge clk);
    while (busy && n < 1000) begin n++; @(negedge clk); end
    chk(n == 80, "R6 no gap between frames", n, 80);
  endtask

  task automatic t_abort;
    bit quiet = 1;
    divisor = 8; fmt = 4'b1110;
    push(8'h3C);
    repeat (30) @(negedge clk);
    chk(busy == 1, "R8 frame running", busy, 1);
    soft_rst = 1;
    @(negedge clk);
    soft_rst = 0;
    chk(busy == 0, "R8 abort busy", busy, 0);
    chk(txd == 1, "R8 abort txd", txd, 1);
    chk(tx_done == 0, "R8 abort done", tx_done, 0);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (txd !== 1'b1 || busy !== 1'b0 || tx_done !== 1'b0) quiet = 0;
    end
    chk(quiet, "R8 aborted frame not resumed", quiet, 1);
  endtask

  initial begin
    wr = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_parity();
    t_lengths();
    t_b2b();
    t_abort();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule